// File: doc/BRIEF.md
# Load-Use Hazard Detection Unit

This block decides, every cycle, whether the decode stage of a five-stage in-order pipeline must wait. It looks at the two source register numbers of the instruction being decoded and at the destination of the instruction or instructions ahead of it. When a wait is needed, it holds the program counter and the fetch/decode pipeline register. It also replaces the control word heading into the execute stage with all zeros, so that a do-nothing instruction moves down the pipe in its place.

A parameter selects one of two variants. In forwarding mode the pipeline has bypass paths, so only one case must wait: a load in execute whose loaded register is read by the very next instruction. The loaded value does not exist until the memory stage ends. In stall-only mode there are no bypass paths, so decode waits for as long as any instruction still in execute or memory is due to write a register that decode reads. Every pin is a plain level signal and the whole block is combinational. It has no stream interface, so no valid/ready handshake or back-pressure applies.

Top module: `hazard_unit`

## Requirements
- R1: In forwarding mode, `stall_bubble` is 1 when `ex_mem_read` is 1, `ex_dst` is nonzero, and `ex_dst` equals `id_rs` or `id_rt`.
- R2: In forwarding mode, `stall_bubble` is 0 whenever the R1 condition is false. `ex_reg_write`, `mem_reg_write` and `mem_dst` have no effect on it.
- R3: A destination register number of 0 never causes a stall, in either mode.
- R4: In stall-only mode, `stall_bubble` is 1 in either of two cases. The first is when `ex_reg_write` is 1 and a nonzero `ex_dst` equals `id_rs` or `id_rt`. The second is when `mem_reg_write` is 1 and a nonzero `mem_dst` equals `id_rs` or `id_rt`.
- R5: In stall-only mode, a destination whose write-enable flag is 0 never causes a stall. `ex_mem_read` has no effect.
- R6: `pc_write` and `ifid_write` are both equal to the inverse of `stall_bubble`.
- R7: `ctrl_out` equals `ctrl_in` when `stall_bubble` is 0, and equals all zeros when it is 1.
- R8: In forwarding mode, a load followed directly by a dependent instruction stalls for exactly one cycle. After the bubble moves in behind the load, the held instruction no longer stalls. A load followed by an independent instruction does not stall at all.
- R9: In stall-only mode, the stall repeats every cycle while the producer sits in execute and then in memory, and it clears once the producer has left both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_W | First source register of the instruction in decode |
| id_rt | input | REG_W | Second source register of the instruction in decode |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| ex_reg_write | input | 1 | Instruction in execute writes a register |
| ex_dst | input | REG_W | Destination register of the instruction in execute |
| mem_reg_write | input | 1 | Instruction in memory writes a register |
| mem_dst | input | REG_W | Destination register of the instruction in memory |
| ctrl_in | input | CTRL_W | Decoded control word for the execute-stage register |
| ctrl_out | output | CTRL_W | Control word actually loaded, zero on a bubble |
| pc_write | output | 1 | Program counter load enable |
| ifid_write | output | 1 | Fetch/decode register load enable |
| stall_bubble | output | 1 | High while a bubble is injected |

## Verification
The bench covers every combination of register numbers and flags in a 3-bit register configuration, for both modes side by side. This exposes a unit that stalls on register 0, that matches only one of the two sources, that lets a disabled destination count, or that looks at the memory stage in forwarding mode. A design with any of these faults would produce a spurious or missing stall. Short cycle-by-cycle sequences then move a bubble behind a load, and a producer through execute and memory. A stall that fails to clear would hang decode, and one that clears early would let a stale operand through.

// File: rtl/hdu_pkg.sv
package hdu_pkg;
  typedef enum logic {
    MODE_FORWARD    = 1'b0,
    MODE_STALL_ONLY = 1'b1
  } hdu_mode_e;
endpackage

// File: rtl/hdu_src_match.sv
module hdu_src_match #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic                       dst_valid,
  input  logic [REG_W-1:0]           dst,
  input  logic [NSRC-1:0][REG_W-1:0] srcs,
  output logic                       hit
);
  logic [NSRC-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_cmp
      assign eq[g] = (srcs[g] == dst);
    end
  endgenerate

  // register 0 is hard-wired, never a real producer
  assign hit = dst_valid && (dst != '0) && (|eq);
endmodule

// File: rtl/hdu_bubble_mux.sv
module hdu_bubble_mux #(
  parameter int CTRL_W = 8
) (
  input  logic              stall,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic              bubble
);
  assign bubble   = stall;
  assign ctrl_out = stall ? '0 : ctrl_in;

  always_comb begin
    // R7
    ctrl_zero_chk: assert (!bubble || ctrl_out == '0);
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hdu_pkg::*;
#(
  parameter int        REG_W  = 5,
  parameter int        CTRL_W = 8,
  parameter hdu_mode_e MODE   = MODE_FORWARD
) (
  input  logic [REG_W-1:0]  id_rs,
  input  logic [REG_W-1:0]  id_rt,
  input  logic              ex_mem_read,
  input  logic              ex_reg_write,
  input  logic [REG_W-1:0]  ex_dst,
  input  logic              mem_reg_write,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic              pc_write,
  output logic              ifid_write,
  output logic              stall_bubble
);
  localparam bit STALL_ONLY = (MODE == MODE_STALL_ONLY);
  localparam int NSRC       = 2;

  logic [NSRC-1:0][REG_W-1:0] id_srcs;
  logic ex_qual, mem_qual, ex_hit, mem_hit, stall;

  assign id_srcs = {id_rt, id_rs};
  // forwarding covers everything except a load still in execute
  assign ex_qual  = STALL_ONLY ? ex_reg_write : ex_mem_read;
  assign mem_qual = STALL_ONLY ? mem_reg_write : 1'b0;

  hdu_src_match #(.REG_W(REG_W), .NSRC(NSRC)) ex_cmp_i (
    .dst_valid (ex_qual),
    .dst       (ex_dst),
    .srcs      (id_srcs),
    .hit       (ex_hit)
  );

  hdu_src_match #(.REG_W(REG_W), .NSRC(NSRC)) mem_cmp_i (
    .dst_valid (mem_qual),
    .dst       (mem_dst),
    .srcs      (id_srcs),
    .hit       (mem_hit)
  );

  assign stall = ex_hit | mem_hit;

  hdu_bubble_mux #(.CTRL_W(CTRL_W)) mux_i (
    .stall    (stall),
    .ctrl_in  (ctrl_in),
    .ctrl_out (ctrl_out),
    .bubble   (stall_bubble)
  );

  assign pc_write   = ~stall;
  assign ifid_write = ~stall;

  always_comb begin
    // R6
    freeze_vs_bubble_chk: assert (pc_write == ifid_write && pc_write != stall_bubble);
    // R3
    zero_dst_chk: assert (!((ex_dst == '0) && (mem_dst == '0)) || !stall_bubble);
    // R2
    load_only_chk: assert (STALL_ONLY || ex_mem_read || !stall_bubble);
    // R5
    wr_enable_chk: assert (!STALL_ONLY || ex_reg_write || mem_reg_write || !stall_bubble);
  end
endmodule

// File: tb/hazard_unit_tb.sv
module hazard_unit_tb_top;
  import hdu_pkg::*;
  localparam int RW = 3;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [RW-1:0] rs, rt, exd, memd;
  logic exmr, exrw, memrw;
  logic [CW-1:0] cin;
  logic [CW-1:0] co_f, co_s;
  logic pcw_f, ifw_f, bub_f, pcw_s, ifw_s, bub_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hazard_unit #(.REG_W(RW), .CTRL_W(CW), .MODE(MODE_FORWARD)) dut_i (
    .id_rs(rs), .id_rt(rt), .ex_mem_read(exmr), .ex_reg_write(exrw), .ex_dst(exd),
    .mem_reg_write(memrw), .mem_dst(memd), .ctrl_in(cin), .ctrl_out(co_f),
    .pc_write(pcw_f), .ifid_write(ifw_f), .stall_bubble(bub_f));

  hazard_unit #(.REG_W(RW), .CTRL_W(CW), .MODE(MODE_STALL_ONLY)) dut_so_i (
    .id_rs(rs), .id_rt(rt), .ex_mem_read(exmr), .ex_reg_write(exrw), .ex_dst(exd),
    .mem_reg_write(memrw), .mem_dst(memd), .ctrl_in(cin), .ctrl_out(co_s),
    .pc_write(pcw_s), .ifid_write(ifw_s), .stall_bubble(bub_s));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (rs=%0d rt=%0d exd=%0d memd=%0d f=%b%b%b)",
               req, act, exp, rs, rt, exd, memd, exmr, exrw, memrw);
    end
  endtask

  task automatic drive(input logic [RW-1:0] a, input logic [RW-1:0] b,
                       input logic mr, input logic xw, input logic [RW-1:0] xd,
                       input logic mw, input logic [RW-1:0] md);
    @(negedge clk);
    rs = a; rt = b; exmr = mr; exrw = xw; exd = xd; memrw = mw; memd = md;
    #2;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cin = 8'hA5;
    drive('0, '0, 1'b0, 1'b0, '0, 1'b0, '0);
    // idle state: no stall, enables high, control passes through
    chk("R2 idle", {pcw_f, ifw_f, bub_f}, 3'b110);
    chk("R7 idle", co_f, 8'hA5);

    for (int v = 0; v < (1 << (4*RW + 3)); v++) begin
      logic [RW-1:0] a, b, xd, md;
      logic mr, xw, mw, hf, hs, mtx, mtm;
      a  = v[RW-1:0];
      b  = v[2*RW-1:RW];
      xd = v[3*RW-1:2*RW];
      md = v[4*RW-1:3*RW];
      {mr, xw, mw} = v[4*RW+2:4*RW];
      cin = CW'(v * 37 + 1);
      drive(a, b, mr, xw, xd, mw, md);
      mtx = (xd != 0) && (xd == a || xd == b);
      mtm = (md != 0) && (md == a || md == b);
      hf = mr && mtx;
      hs = (xw && mtx) || (mw && mtm);
      if (hf) chk("R1 load-use stall", bub_f, 1'b1);
      else if (xd == 0) chk("R3 zero dst fwd", bub_f, 1'b0);
      else chk("R2 no stall", bub_f, 1'b0);
      if (!xw && !mw) chk("R5 no writer", bub_s, 1'b0);
      else if (xd == 0 && md == 0) chk("R3 zero dst so", bub_s, 1'b0);
      else chk("R4 stall-only", bub_s, hs);
      chk("R6 fwd enables", {pcw_f, ifw_f}, {2{~hf}});
      chk("R6 so enables", {pcw_s, ifw_s}, {2{~hs}});
      chk("R7 fwd ctrl", co_f, hf ? 8'h00 : cin);
      chk("R7 so ctrl", co_s, hs ? 8'h00 : cin);
    end

    cin = 8'h3C;
    // R8: lw r4 in EX, sub r5,r2,r4 in decode -> one stall
    drive(3'd2, 3'd4, 1'b1, 1'b1, 3'd4, 1'b0, 3'd0);
    chk("R8 first cycle stalls", bub_f, 1'b1);
    // bubble enters EX, load moves to MEM; sub still in decode
    drive(3'd2, 3'd4, 1'b0, 1'b0, 3'd0, 1'b1, 3'd4);
    chk("R8 second cycle clear", bub_f, 1'b0);
    chk("R8 ctrl passes", co_f, 8'h3C);
    // independent instruction after lw
    drive(3'd2, 3'd3, 1'b1, 1'b1, 3'd4, 1'b0, 3'd0);
    chk("R8 independent no stall", bub_f, 1'b0);

    // R9: add r1 in EX, sub r5,r1,r2 in decode
    drive(3'd1, 3'd2, 1'b0, 1'b1, 3'd1, 1'b0, 3'd0);
    chk("R9 producer in EX", bub_s, 1'b1);
    drive(3'd1, 3'd2, 1'b0, 1'b0, 3'd0, 1'b1, 3'd1);
    chk("R9 producer in MEM", bub_s, 1'b1);
    drive(3'd1, 3'd2, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0);
    chk("R9 producer gone", bub_s, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule